// File: doc/BRIEF.md
# Two-Dimensional Word Address Generator

The block walks a rectangular region of memory and emits one byte address per 16-bit word. It runs over a number of rows, and each row holds a programmed number of elements. Inside a row the address moves by an inner stride. When the last element of a row is accepted, a separate outer stride is applied instead of the inner stride. Both strides are in bytes and are signed. With both strides set to 2 the block scans a contiguous buffer, which suits framebuffer read-out, for example 480 words per line over 241 lines. An outer stride of (line_pixels − W)×3+2 makes it walk a W-pixel-wide window of three-byte pixels inside a wider line, which suits rectangular blits.

A rising edge on the enable input captures the whole configuration and starts the walk. Addresses are offered on a valid/ready pair. In stop mode the generator halts after the final element and raises a sticky done flag. In autobuffer mode it returns to the start address and carries on with no idle cycle. Software reads the running and done flags. It clears done with a single-cycle clear pulse.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While reset is held and directly after it, addr_valid_o, running_o, done_o and last_o are all 0.
- R2: A 0→1 transition of enable_i latches every cfg_* input. From the next cycle running_o and addr_valid_o are 1 and addr_o equals the start address.
- R3: addr_o changes only after a cycle in which addr_valid_o and addr_ready_i are both 1. Under a stall it holds its value.
- R4: After an accepted element that is not the last of its row, addr_o increases by cfg_x_stride_i. The stride is a two's-complement byte offset, and each element is one 16-bit word.
- R5: After the last accepted element of a row that is not the final row, addr_o increases by cfg_y_stride_i. The inner stride is not applied in that case.
- R6: A transfer has cfg_x_count_i elements per row and cfg_y_count_i rows. A count of 0 acts as 1.
- R7: last_o is 1 exactly while the final element of the transfer is being offered.
- R8: With cfg_auto_i=0, acceptance of the final element makes running_o and addr_valid_o 0 from the next cycle. They stay 0 until enable_i rises again.
- R9: With cfg_auto_i=1, acceptance of the final element makes addr_o equal the latched start address in the next cycle. addr_valid_o stays 1 and the count restarts.
- R10: done_o becomes 1 after every accepted final element, in either mode. It stays 1 until a cycle with done_clr_i=1, and a set in the same cycle as a clear wins.
- R11: Changes to cfg_* inputs while running have no effect on the address sequence until enable_i rises again.
- R12: Deasserting enable_i makes addr_valid_o and running_o 0 from the next cycle. done_o is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Rising edge latches config and starts |
| cfg_start_i | input | ADDR_W | Start byte address |
| cfg_x_count_i | input | CNT_W | Elements per row |
| cfg_x_stride_i | input | STRIDE_W | Signed byte step inside a row |
| cfg_y_count_i | input | CNT_W | Rows per transfer |
| cfg_y_stride_i | input | STRIDE_W | Signed byte step after a row's last element |
| cfg_auto_i | input | 1 | 1: autobuffer restart, 0: stop when finished |
| done_clr_i | input | 1 | Clear pulse for done_o |
| addr_valid_o | output | 1 | Address offered |
| addr_ready_i | input | 1 | Consumer accepts the address |
| addr_o | output | ADDR_W | Current byte address |
| last_o | output | 1 | Offered element is the transfer's final one |
| running_o | output | 1 | Generator active |
| done_o | output | 1 | Sticky completion flag |

## Verification
The bench builds the generator with ADDR_W=24, CNT_W=10 and STRIDE_W=16. These values keep row and column counts small enough that many complete transfers fit in one run. A 24-bit address with a 16-bit signed stride exercises sign extension and the wrap of negative outer strides below the start address. Random ready patterns make stalls fall on row ends and on the final element. Zero counts, autobuffer wrap over several frames, and mid-run configuration changes are each reached directly.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [0:0] {
    FLOW_STOP = 1'b0,
    FLOW_AUTO = 1'b1
  } flow_e;
endpackage

// File: rtl/dma2d_axis_cnt.sv
module dma2d_axis_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             step_i,
  output logic             last_o
);
  logic [CNT_W-1:0] lim_q, idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      // zero count behaves as one element
      lim_q <= (count_i == '0) ? '0 : count_i - 1'b1;
      idx_q <= '0;
    end else if (step_i) begin
      idx_q <= last_o ? '0 : idx_q + 1'b1;
    end
  end

  assign last_o = (idx_q == lim_q);

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= lim_q); // R6
endmodule

// File: rtl/dma2d_addr_acc.sv
module dma2d_addr_acc #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   start_i,
  input  logic [STRIDE_W-1:0] x_stride_i,
  input  logic [STRIDE_W-1:0] y_stride_i,
  input  logic                step_i,
  input  logic                row_end_i,
  input  logic                final_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [ADDR_W-1:0]   start_o
);
  localparam int EXT_W = ADDR_W - STRIDE_W;

  logic [ADDR_W-1:0]   addr_q, start_q, delta;
  logic [STRIDE_W-1:0] xs_q, ys_q, sel;

  assign sel   = row_end_i ? ys_q : xs_q;
  assign delta = {{EXT_W{sel[STRIDE_W-1]}}, sel};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      start_q <= '0;
      xs_q    <= '0;
      ys_q    <= '0;
    end else if (load_i) begin
      addr_q  <= start_i;
      start_q <= start_i;
      xs_q    <= x_stride_i;
      ys_q    <= y_stride_i;
    end else if (step_i) begin
      addr_q  <= final_i ? start_q : addr_q + delta;
    end
  end

  assign addr_o  = addr_q;
  assign start_o = start_q;

  AST_HOLD_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(addr_q)); // R3
endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  enable_i,
  input  logic  auto_i,
  input  logic  hs_i,
  input  logic  final_i,
  input  logic  done_clr_i,
  output logic  load_o,
  output logic  running_o,
  output logic  done_o,
  output flow_e flow_o
);
  logic  en_q, run_q, done_q;
  flow_e flow_q;

  assign load_o = enable_i & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      flow_q <= FLOW_STOP;
    end else begin
      en_q <= enable_i;
      if (load_o) flow_q <= auto_i ? FLOW_AUTO : FLOW_STOP;
      if (!enable_i)                                 run_q <= 1'b0;
      else if (load_o)                               run_q <= 1'b1;
      else if (hs_i && final_i && flow_q == FLOW_STOP) run_q <= 1'b0;
      // set has priority over clear
      if (hs_i && final_i) done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
    end
  end

  assign running_o = run_q;
  assign done_o    = done_q;
  assign flow_o    = flow_q;

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !done_clr_i) |=> done_q); // R10
  AST_DISABLE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !run_q); // R12
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int STRIDE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic [ADDR_W-1:0]   cfg_start_i,
  input  logic [CNT_W-1:0]    cfg_x_count_i,
  input  logic [STRIDE_W-1:0] cfg_x_stride_i,
  input  logic [CNT_W-1:0]    cfg_y_count_i,
  input  logic [STRIDE_W-1:0] cfg_y_stride_i,
  input  logic                cfg_auto_i,
  input  logic                done_clr_i,
  output logic                addr_valid_o,
  input  logic                addr_ready_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic                last_o,
  output logic                running_o,
  output logic                done_o
);
  logic        load, run, hs, x_last, y_last, final_el;
  logic [ADDR_W-1:0] start_q;
  flow_e       flow;

  assign hs       = run & addr_ready_i;
  assign final_el = x_last & y_last;

  dma2d_ctrl u_ctrl (
    .clk_i, .rst_ni, .enable_i,
    .auto_i    (cfg_auto_i),
    .hs_i      (hs),
    .final_i   (final_el),
    .done_clr_i,
    .load_o    (load),
    .running_o (run),
    .done_o,
    .flow_o    (flow)
  );

  dma2d_axis_cnt #(.CNT_W(CNT_W)) u_x_cnt (
    .clk_i, .rst_ni,
    .load_i  (load),
    .count_i (cfg_x_count_i),
    .step_i  (hs),
    .last_o  (x_last)
  );

  dma2d_axis_cnt #(.CNT_W(CNT_W)) u_y_cnt (
    .clk_i, .rst_ni,
    .load_i  (load),
    .count_i (cfg_y_count_i),
    .step_i  (hs & x_last),
    .last_o  (y_last)
  );

  dma2d_addr_acc #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_acc (
    .clk_i, .rst_ni,
    .load_i     (load),
    .start_i    (cfg_start_i),
    .x_stride_i (cfg_x_stride_i),
    .y_stride_i (cfg_y_stride_i),
    .step_i     (hs),
    .row_end_i  (x_last),
    .final_i    (final_el),
    .addr_o,
    .start_o    (start_q)
  );

  assign addr_valid_o = run;
  assign running_o    = run;
  assign last_o       = run & final_el;

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_ready_i && enable_i) |=> $stable(addr_o)); // R3
  AST_FINAL_SETS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && addr_ready_i && last_o) |=> done_o); // R10
  AST_STOP_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && addr_ready_i && last_o && flow == FLOW_STOP) |=> !addr_valid_o); // R8
  AST_AUTO_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && addr_ready_i && last_o && flow == FLOW_AUTO && enable_i)
      |=> (addr_valid_o && addr_o == start_q)); // R9
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> addr_valid_o); // R7
endmodule

// File: tb/dma2d_addr_gen_test.sv
module dma2d_addr_gen_test;
  localparam int AW = 24, CW = 10, SW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, auto_m = 0, done_clr = 0, ready = 0;
  logic [AW-1:0] start = '0;
  logic [CW-1:0] xc = '0, yc = '0;
  logic [SW-1:0] xs = '0, ys = '0;
  logic valid, last, running, done;
  logic [AW-1:0] addr;
  int checks = 0, fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  dma2d_addr_gen #(.ADDR_W(AW), .CNT_W(CW), .STRIDE_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .cfg_start_i(start), .cfg_x_count_i(xc), .cfg_x_stride_i(xs),
    .cfg_y_count_i(yc), .cfg_y_stride_i(ys), .cfg_auto_i(auto_m),
    .done_clr_i(done_clr), .addr_valid_o(valid), .addr_ready_i(ready),
    .addr_o(addr), .last_o(last), .running_o(running), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [AW-1:0] sx(input logic [SW-1:0] s);
    return {{(AW-SW){s[SW-1]}}, s};
  endfunction

  function automatic int eff(input logic [CW-1:0] c);
    return (c == '0) ? 1 : int'(c);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // program and start; returns at negedge after the load edge
  task automatic launch(input logic [AW-1:0] s, input int x, input int y,
                        input logic [SW-1:0] a, input logic [SW-1:0] b, input bit au);
    @(negedge clk);
    enable = 0; ready = 0;
    start = s; xc = x[CW-1:0]; yc = y[CW-1:0]; xs = a; ys = b; auto_m = au;
    @(negedge clk);
    enable = 1;
    @(negedge clk);
    #1;
    chk(valid && running && addr == s, "R2 start", {addr, 7'd0, valid}, {s, 8'd1});
  endtask

  // walks frames, checking every accepted address
  task automatic walk(input int frames, input int pct, input bit mutate,
                      input logic [AW-1:0] s, input int x, input int y,
                      input logic [SW-1:0] a, input logic [SW-1:0] b, input bit au);
    logic [AW-1:0] exp = s;
    int c = 0, r = 0, f = 0;
    int xe = eff(x[CW-1:0]), ye = eff(y[CW-1:0]);
    bit fin;
    while (f < frames) begin
      ready = ($urandom % 100) < pct;
      if (mutate) begin
        start = $urandom; xs = $urandom; ys = $urandom;
        xc = $urandom; yc = $urandom; auto_m = ~au;
      end
      #1;
      fin = (c == xe-1) && (r == ye-1);
      chk(valid == 1'b1, "R8 valid during run", valid, 1);
      chk(last == fin, "R7 last", last, fin);
      chk(addr == exp, mutate ? "R11 latched cfg" : (c == 0 && r > 0 ? "R5 row stride" : "R4 addr"), addr, exp);
      if (ready) begin
        if (fin) begin exp = s; c = 0; r = 0; f++; end
        else if (c == xe-1) begin exp = exp + sx(b); c = 0; r++; end
        else begin exp = exp + sx(a); c++; end
      end
      @(negedge clk);
    end
    ready = 0;
    #1;
    if (au) begin
      chk(valid && addr == s, "R9 wrap to start", addr, s);
    end else begin
      chk(!valid && !running, "R8 stopped", {valid, running}, 0);
    end
    chk(done == 1'b1, "R10 done set", done, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(!valid && !running && !done && !last, "R1 in reset", {valid, running, done, last}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!valid && !running && !done && !last, "R1 after reset", {valid, running, done, last}, 0);

    // contiguous scan, full ready (R4, R6)
    launch(24'h001000, 6, 3, 16'd2, 16'd2, 0);
    walk(1, 100, 0, 24'h001000, 6, 3, 16'd2, 16'd2, 0);

    // R10: sticky after stop, then clear
    repeat (5) @(negedge clk);
    #1; chk(done && !valid, "R10 sticky", done, 1);
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0; #1;
    chk(!done, "R10 cleared", done, 0);
    // R8: stays stopped while enable held
    chk(!valid && !running, "R8 held stop", valid, 0);

    // blit window into 20-pixel line, width 4 pixels: 6 words, outer (20-4)*3+2
    launch(24'h002000, 6, 4, 16'd2, 16'd50, 0);
    walk(1, 60, 0, 24'h002000, 6, 4, 16'd2, 16'd50, 0);

    // R6 zero counts act as one
    launch(24'h003000, 0, 0, 16'd2, 16'd2, 0);
    walk(1, 50, 0, 24'h003000, 0, 0, 16'd2, 16'd2, 0);

    // R3 stall: ready low holds address
    launch(24'h004000, 3, 2, 16'd4, 16'd8, 0);
    repeat (4) @(negedge clk);
    #1; chk(addr == 24'h004000 && valid, "R3 stall hold", addr, 24'h004000);
    walk(1, 40, 0, 24'h004000, 3, 2, 16'd4, 16'd8, 0);

    // R11 config changes during run ignored
    launch(24'h005000, 5, 3, 16'd2, 16'hFFF0, 0);
    walk(1, 70, 1, 24'h005000, 5, 3, 16'd2, 16'hFFF0, 0);

    // R9 autobuffer across frames
    launch(24'h006000, 3, 2, 16'd2, 16'd10, 1);
    walk(3, 75, 0, 24'h006000, 3, 2, 16'd2, 16'd10, 1);

    // R12 disable mid-run, done unchanged
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
    launch(24'h007000, 8, 8, 16'd2, 16'd2, 0);
    ready = 1; repeat (5) @(negedge clk);
    ready = 0; enable = 0; @(negedge clk); #1;
    chk(!valid && !running && !done, "R12 disable", {valid, running, done}, 0);

    // random transfers, some negative strides
    for (int i = 0; i < 30; i++) begin
      logic [AW-1:0] s = $urandom;
      int x = $urandom_range(0, 12);
      int y = $urandom_range(0, 6);
      logic [SW-1:0] a = (i % 3 == 0) ? 16'hFFFE : 16'd2;
      logic [SW-1:0] b = $urandom;
      bit au = (i % 4 == 0);
      launch(s, x, y, a, b, au);
      walk(au ? 2 : 1, $urandom_range(30, 100), 0, s, x, y, a, b, au);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule